// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Bank

This block lets two independent processors coordinate access to shared resources through a bank of eight hardware ownership flags. Each side has its own active-low select, write strobe, output enable, address bus and data bus. A side claims a flag by writing a zero and gives it back by writing a one. The flags only report who holds a token. They never block access to anything in hardware, so software sets the usage rules.

When a side tries to claim a flag that the other side holds, the claim is parked in that side's request latch. It is granted with no further action once the holder releases. A side may withdraw a parked claim by writing a one. Reads report the flag as that side sees it, spread across every data bit. The value is frozen from the first cycle of an access until the access ends, so a polling loop has to drop its select or output enable between reads. Everything is synchronous to one clock. Reset is asserted asynchronously and leaves reset on a clock edge.

Top module: `dp_sem_unit`

## Requirements
- R1: After reset, every flag reads as all ones from both sides, and no claim is parked.
- R2: The flag is picked by the three lowest address bits only. Every higher address bit has no effect on reads or writes.
- R3: A write takes effect only in a clock cycle where both select and write strobe are low. Only data bit 0 matters: 0 claims the flag, 1 releases it.
- R4: When a free flag is claimed, the claiming side reads 0 and the other side reads 1. Writes of 1 from the other side then leave the flag owned.
- R5: A claim from the side that does not own the flag is parked. It is granted to that side as soon as the owner writes 1.
- R6: An owner writing 1 while nothing is parked frees the flag, so both sides read 1.
- R7: Read data is all ones when the flag is 1 for that side and all zeros when it is 0.
- R8: Read data appears one cycle after the access starts, where an access is select low, output enable low and write strobe high. Read data is zero in every cycle after a clock edge at which no access was active.
- R9: Read data stays at the value captured at the start of an access for as long as the access continues, even if the flag changes. A new access shows the new value.
- R10: When both sides claim the same free flag in the same cycle, the left side gets it and the right side's claim is parked.
- R11: A side with a parked claim that writes 1 withdraws the claim. A later release by the owner then leaves the flag free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_l_n | input | 1 | Left semaphore select, active low |
| we_l_n | input | 1 | Left write strobe, active low |
| oe_l_n | input | 1 | Left output enable, active low |
| addr_l | input | AW | Left address; low three bits pick the flag |
| wdata_l | input | DW | Left write data; bit 0 used |
| rdata_l | output | DW | Left read data |
| sel_r_n | input | 1 | Right semaphore select, active low |
| we_r_n | input | 1 | Right write strobe, active low |
| oe_r_n | input | 1 | Right output enable, active low |
| addr_r | input | AW | Right address; low three bits pick the flag |
| wdata_r | input | DW | Right write data; bit 0 used |
| rdata_r | output | DW | Right read data |

## Verification
The bench aims at the same-cycle tie on a free flag. A design without a fixed winner would grant both sides or neither, and the right side would later see no automatic grant. It also holds a right-side read open while the left side releases to that parked claimant. A design that does not freeze read data would show the new ownership in the middle of the access. Other targets are withdrawal of a parked claim, where a stale latch would hand the flag to a side that gave up, and writes whose upper address and data bits are set, where a full-width decode would miss the flag.

// File: rtl/dp_sem_pkg.sv
package dp_sem_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  typedef struct packed {
    logic claim;
    logic drop;
  } wr_strobe_t;

endpackage

// File: rtl/sem_wr_decode.sv
module sem_wr_decode #(
  parameter int NFLAGS = 8,
  parameter int AW     = 14,
  parameter int DW     = 16,
  localparam int IDXW  = $clog2(NFLAGS)
) (
  input  logic              sel_n,
  input  logic              we_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output dp_sem_pkg::wr_strobe_t [NFLAGS-1:0] strobe
);

  logic              wr_act;
  logic [IDXW-1:0]   idx;
  logic              unused_high_bits;

  assign wr_act = ~sel_n & ~we_n;
  assign idx    = addr[IDXW-1:0];
  assign unused_high_bits = ^{addr[AW-1:IDXW], wdata[DW-1:1]};

  for (genvar g = 0; g < NFLAGS; g++) begin : g_dec
    logic hit;
    assign hit             = wr_act && (idx == IDXW'(g));
    assign strobe[g].claim = hit & ~wdata[0];
    assign strobe[g].drop  = hit &  wdata[0];
  end

endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell (
  input  logic                   clk,
  input  logic                   rst_n,
  input  dp_sem_pkg::wr_strobe_t wr_l,
  input  dp_sem_pkg::wr_strobe_t wr_r,
  output logic                   view_l,
  output logic                   view_r
);
  import dp_sem_pkg::*;

  owner_e owner_q, owner_mid, owner_d;
  logic   req_l_q, req_r_q, req_l_d, req_r_d;
  logic   req_l_eff, req_r_eff;
  logic   upd_en;

  assign upd_en = wr_l.claim | wr_l.drop | wr_r.claim | wr_r.drop;

  always_comb begin
    req_l_eff = wr_l.claim | (req_l_q & ~wr_l.drop);
    req_r_eff = wr_r.claim | (req_r_q & ~wr_r.drop);

    owner_mid = owner_q;
    if (owner_q == OWN_LEFT  && wr_l.drop) owner_mid = OWN_NONE;
    if (owner_q == OWN_RIGHT && wr_r.drop) owner_mid = OWN_NONE;

    owner_d = owner_mid;
    if (owner_mid == OWN_NONE) begin
      if (req_l_eff)      owner_d = OWN_LEFT;
      else if (req_r_eff) owner_d = OWN_RIGHT;
    end

    req_l_d = req_l_eff & (owner_d != OWN_LEFT);
    req_r_d = req_r_eff & (owner_d != OWN_RIGHT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
    end else if (upd_en) begin
      owner_q <= owner_d;
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
    end
  end

  assign view_l = (owner_q != OWN_LEFT);
  assign view_r = (owner_q != OWN_RIGHT);

endmodule

// File: rtl/sem_read_hold.sv
module sem_read_hold #(
  parameter int NFLAGS = 8,
  parameter int AW     = 14,
  parameter int DW     = 16,
  localparam int IDXW  = $clog2(NFLAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [AW-1:0]     addr,
  input  logic [NFLAGS-1:0] flags,
  output logic [DW-1:0]     rdata
);

  logic act, act_q, act_d;
  logic bit_q, bit_d;
  logic cap_en;
  logic unused_addr_high;

  assign unused_addr_high = ^addr[AW-1:IDXW];
  assign act    = ~sel_n & ~oe_n & we_n;
  assign cap_en = act & ~act_q;

  always_comb begin
    act_d = act;
    bit_d = bit_q;
    if (cap_en) bit_d = flags[addr[IDXW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      bit_q <= 1'b1;
    end else begin
      act_q <= act_d;
      bit_q <= bit_d;
    end
  end

  assign rdata = act_q ? {DW{bit_q}} : '0;

endmodule

// File: rtl/dp_sem_unit.sv
module dp_sem_unit #(
  parameter int NFLAGS = 8,
  parameter int AW     = 14,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_l_n,
  input  logic          we_l_n,
  input  logic          oe_l_n,
  input  logic [AW-1:0] addr_l,
  input  logic [DW-1:0] wdata_l,
  output logic [DW-1:0] rdata_l,
  input  logic          sel_r_n,
  input  logic          we_r_n,
  input  logic          oe_r_n,
  input  logic [AW-1:0] addr_r,
  input  logic [DW-1:0] wdata_r,
  output logic [DW-1:0] rdata_r
);
  import dp_sem_pkg::*;

  logic [1:0]                 rst_pipe_q;
  logic                       rst_sync_n;
  wr_strobe_t [NFLAGS-1:0]    strb_l, strb_r;
  logic [NFLAGS-1:0]          vis_l, vis_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  sem_wr_decode #(.NFLAGS(NFLAGS), .AW(AW), .DW(DW)) u_dec_l (
    .sel_n(sel_l_n), .we_n(we_l_n), .addr(addr_l), .wdata(wdata_l), .strobe(strb_l)
  );
  sem_wr_decode #(.NFLAGS(NFLAGS), .AW(AW), .DW(DW)) u_dec_r (
    .sel_n(sel_r_n), .we_n(we_r_n), .addr(addr_r), .wdata(wdata_r), .strobe(strb_r)
  );

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    sem_flag_cell u_cell (
      .clk(clk), .rst_n(rst_sync_n),
      .wr_l(strb_l[g]), .wr_r(strb_r[g]),
      .view_l(vis_l[g]), .view_r(vis_r[g])
    );
  end

  sem_read_hold #(.NFLAGS(NFLAGS), .AW(AW), .DW(DW)) u_rd_l (
    .clk(clk), .rst_n(rst_sync_n), .sel_n(sel_l_n), .we_n(we_l_n), .oe_n(oe_l_n),
    .addr(addr_l), .flags(vis_l), .rdata(rdata_l)
  );
  sem_read_hold #(.NFLAGS(NFLAGS), .AW(AW), .DW(DW)) u_rd_r (
    .clk(clk), .rst_n(rst_sync_n), .sel_n(sel_r_n), .we_n(we_r_n), .oe_n(oe_r_n),
    .addr(addr_r), .flags(vis_r), .rdata(rdata_r)
  );

endmodule

// File: rtl/dp_sem_checker.sv
module dp_sem_checker #(
  parameter int NFLAGS = 8,
  parameter int AW     = 14,
  parameter int DW     = 16,
  localparam int IDXW  = $clog2(NFLAGS)
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              sel_l_n, we_l_n, oe_l_n,
  input logic [AW-1:0]     addr_l,
  input logic [DW-1:0]     wdata_l,
  input logic [DW-1:0]     rdata_l,
  input logic              sel_r_n, we_r_n, oe_r_n,
  input logic [AW-1:0]     addr_r,
  input logic [DW-1:0]     wdata_r,
  input logic [DW-1:0]     rdata_r,
  input logic [NFLAGS-1:0] vis_l,
  input logic [NFLAGS-1:0] vis_r
);

  logic act_l, act_r, wl, wr;
  logic unused_chk_bits;
  assign unused_chk_bits = ^{addr_l[AW-1:IDXW], addr_r[AW-1:IDXW], wdata_l[DW-1:1], wdata_r[DW-1:1]};
  assign act_l = ~sel_l_n & ~oe_l_n & we_l_n;
  assign act_r = ~sel_r_n & ~oe_r_n & we_r_n;
  assign wl    = ~sel_l_n & ~we_l_n;
  assign wr    = ~sel_r_n & ~we_r_n;

  // R7: read data is uniform
  p_uniform_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rdata_l == '0 || rdata_l == '1) && (rdata_r == '0 || rdata_r == '1));

  // R9: held while access continues
  p_hold_l_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (act_l && $past(act_l)) |=> $stable(rdata_l));
  p_hold_r_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (act_r && $past(act_r)) |=> $stable(rdata_r));

  // R8: idle read data is zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!act_l && !act_r) |=> (rdata_l == '0 && rdata_r == '0));

  for (genvar g = 0; g < NFLAGS; g++) begin : g_chk
    logic lc, ld, rc, rd;
    assign lc = wl && addr_l[IDXW-1:0] == IDXW'(g) && !wdata_l[0];
    assign ld = wl && addr_l[IDXW-1:0] == IDXW'(g) &&  wdata_l[0];
    assign rc = wr && addr_r[IDXW-1:0] == IDXW'(g) && !wdata_r[0];
    assign rd = wr && addr_r[IDXW-1:0] == IDXW'(g) &&  wdata_r[0];

    // R10: left wins a same-cycle tie
    p_tie_left_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (lc && rc && vis_l[g] && vis_r[g]) |=> (!vis_l[g] && vis_r[g]));
    // R4: ownership kept until owner releases
    p_keep_l_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!vis_l[g] && !ld) |=> !vis_l[g]);
    p_keep_r_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!vis_r[g] && !rd) |=> !vis_r[g]);
    // R5: release with a claim from the other side hands over
    p_handover_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!vis_l[g] && ld && rc) |=> !vis_r[g]);
  end

endmodule

bind dp_sem_unit dp_sem_checker #(.NFLAGS(NFLAGS), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n),
  .sel_l_n(sel_l_n), .we_l_n(we_l_n), .oe_l_n(oe_l_n), .addr_l(addr_l), .wdata_l(wdata_l), .rdata_l(rdata_l),
  .sel_r_n(sel_r_n), .we_r_n(we_r_n), .oe_r_n(oe_r_n), .addr_r(addr_r), .wdata_r(wdata_r), .rdata_r(rdata_r),
  .vis_l(vis_l), .vis_r(vis_r)
);

// File: tb/dp_sem_unit_tb_top.sv
module dp_sem_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NFLAGS = 8;
  localparam int AW = 14;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic sel_l_n, we_l_n, oe_l_n, sel_r_n, we_r_n, oe_r_n;
  logic [AW-1:0] addr_l, addr_r;
  logic [DW-1:0] wdata_l, wdata_r, rdata_l, rdata_r;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_sem_unit #(.NFLAGS(NFLAGS), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .sel_l_n(sel_l_n), .we_l_n(we_l_n), .oe_l_n(oe_l_n), .addr_l(addr_l), .wdata_l(wdata_l), .rdata_l(rdata_l),
    .sel_r_n(sel_r_n), .we_r_n(we_r_n), .oe_r_n(oe_r_n), .addr_r(addr_r), .wdata_r(wdata_r), .rdata_r(rdata_r)
  );

  // model: 0 free, 1 left owns, 2 right owns
  int own [NFLAGS];
  bit ql [NFLAGS];
  bit qr [NFLAGS];
  int n_chk = 0;
  int n_bad = 0;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_apply(bit lw, bit ld, int la, bit rw, bit rd, int ra);
    for (int i = 0; i < NFLAGS; i++) begin
      bit lc = lw && la == i && !ld;
      bit lr = lw && la == i && ld;
      bit rc = rw && ra == i && !rd;
      bit rr = rw && ra == i && rd;
      case (own[i])
        0: begin
          if (lc) begin own[i] = 1; if (rc) qr[i] = 1; end
          else if (rc) own[i] = 2;
        end
        1: begin
          if (lr) begin
            ql[i] = 0;
            own[i] = (rc || (qr[i] && !rr)) ? 2 : 0;
            qr[i] = 0;
          end else if (rc) qr[i] = 1;
          else if (rr) qr[i] = 0;
        end
        default: begin
          if (rr) begin
            qr[i] = 0;
            own[i] = (lc || (ql[i] && !lr)) ? 1 : 0;
            ql[i] = 0;
          end else if (lc) ql[i] = 1;
          else if (lr) ql[i] = 0;
        end
      endcase
    end
  endfunction

  function automatic bit exp_view(bit right, int i);
    return right ? (own[i] != 2) : (own[i] != 1);
  endfunction

  task automatic idle_all();
    sel_l_n = 1; we_l_n = 1; oe_l_n = 1; addr_l = '0; wdata_l = '0;
    sel_r_n = 1; we_r_n = 1; oe_r_n = 1; addr_r = '0; wdata_r = '0;
  endtask

  task automatic wr(bit lw, logic [AW-1:0] la, logic [DW-1:0] ld,
                    bit rw, logic [AW-1:0] ra, logic [DW-1:0] rd);
    if (lw) begin sel_l_n = 0; we_l_n = 0; addr_l = la; wdata_l = ld; end
    if (rw) begin sel_r_n = 0; we_r_n = 0; addr_r = ra; wdata_r = rd; end
    @(posedge clk);
    model_apply(lw, ld[0], int'(la[2:0]), rw, rd[0], int'(ra[2:0]));
    @(negedge clk);
    idle_all();
  endtask

  task automatic rd(bit right, logic [AW-1:0] a, string req);
    bit e = exp_view(right, int'(a[2:0]));
    if (right) begin sel_r_n = 0; oe_r_n = 0; addr_r = a; end
    else       begin sel_l_n = 0; oe_l_n = 0; addr_l = a; end
    @(posedge clk); @(negedge clk);
    check(req, right ? rdata_r : rdata_l, {DW{e}});
    idle_all();
    @(posedge clk); @(negedge clk);
    check("R8", right ? rdata_r : rdata_l, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NFLAGS; i++) begin own[i] = 0; ql[i] = 0; qr[i] = 0; end
    idle_all();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", rdata_l | rdata_r, '0);
    for (int i = 0; i < NFLAGS; i++) begin
      rd(0, AW'(i), "R1"); rd(1, AW'(i), "R1");
    end

    // R4 claim and lockout
    wr(1, 14'h3FFA, 16'h0000, 0, '0, '0);
    rd(0, 14'd2, "R4"); rd(1, 14'd2, "R4");
    wr(0, '0, '0, 1, 14'd2, 16'h0001);
    rd(0, 14'd2, "R4");

    // R2 / R3 upper bits ignored
    wr(0, '0, '0, 1, 14'h1235, 16'hFFFE);
    rd(1, 14'h0005, "R2"); rd(0, 14'h2AAD, "R3");
    // R3 write with select high ignored
    we_l_n = 0; addr_l = 14'd7; wdata_l = '0;
    @(posedge clk); @(negedge clk); idle_all();
    rd(0, 14'd7, "R3");

    // R5 parked claim granted on release
    wr(1, 14'd5, 16'h0000, 0, '0, '0);
    rd(0, 14'd5, "R5");
    wr(0, '0, '0, 1, 14'h0F05, 16'hFFFF);
    rd(0, 14'd5, "R5"); rd(1, 14'd5, "R5");

    // R6 release with nothing parked
    wr(1, 14'd2, 16'h0001, 0, '0, '0);
    rd(0, 14'd2, "R6"); rd(1, 14'd2, "R6");

    // R10 same-cycle tie
    wr(1, 14'd6, 16'h0000, 1, 14'd6, 16'h0000);
    rd(0, 14'd6, "R10"); rd(1, 14'd6, "R10");
    wr(1, 14'd6, 16'h0001, 0, '0, '0);
    rd(1, 14'd6, "R10"); rd(0, 14'd6, "R10");

    // R11 withdrawal
    wr(1, 14'd6, 16'h0000, 0, '0, '0);
    wr(1, 14'd6, 16'h0001, 0, '0, '0);
    wr(0, '0, '0, 1, 14'd6, 16'h0001);
    rd(0, 14'd6, "R11"); rd(1, 14'd6, "R11");

    // R9 hold during access
    wr(1, 14'd1, 16'h0000, 1, 14'd1, 16'h0000);
    sel_r_n = 0; oe_r_n = 0; addr_r = 14'd1;
    @(posedge clk); @(negedge clk);
    check("R9", rdata_r, '1);
    sel_l_n = 0; we_l_n = 0; addr_l = 14'd1; wdata_l = 16'h0001;
    @(posedge clk); model_apply(1, 1, 1, 0, 0, 0); @(negedge clk);
    sel_l_n = 1; we_l_n = 1;
    check("R9", rdata_r, '1);
    @(posedge clk); @(negedge clk);
    check("R9", rdata_r, '1);
    idle_all();
    @(posedge clk); @(negedge clk);
    rd(1, 14'd1, "R9");

    // random mix
    for (int n = 0; n < 400; n++) begin
      bit lw = 1'($urandom);
      bit rw = 1'($urandom);
      logic [AW-1:0] la = AW'($urandom);
      logic [AW-1:0] ra = AW'($urandom);
      logic [DW-1:0] ldat = DW'($urandom);
      logic [DW-1:0] rdat = DW'($urandom);
      wr(lw, la, ldat, rw, ra, rdat);
      rd(1'($urandom), AW'($urandom), "R5");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule